// File: doc/BRIEF.md
# Serial Pattern Recognizer with Lockout

This block watches a one-bit serial stream, consuming one bit on every rising clock edge. Its single output goes high whenever the three most recent bits read 0, 1, 0 in arrival order. The output also depends on whether the stream has ever carried the run 1, 0, 0 since the last reset. Once that run has appeared, the recognizer falls into a dead state that accepts every later bit and keeps the output low. Only a reset brings it back.

The output is a Moore output. It is decoded from the state register alone, so it changes only at clock edges and never responds directly to the data input. Matches may overlap: the final 0 of one 0,1,0 can start the next one. The state register can be stored one-hot or binary. A parameter selects the encoding, and both encodings behave the same at the ports.

Top module: `seq_lockout_recognizer`

## Requirements
- R1: While `rst` is high at a rising edge the machine returns to its start state, and in the cycle after that edge `match` is 0.
- R2: If the bits sampled at three consecutive edges after reset are 0, 1, 0 and no 1,0,0 has appeared, `match` is 1 in the cycle that follows the edge sampling the final 0.
- R3: Matches overlap. The stream 0,1,0,1,0 gives two single-cycle pulses, after the third bit and after the fifth bit.
- R4: Once the bits sampled at three consecutive edges are 1, 0, 0, `match` stays 0 for every later input, including later 0,1,0 runs, until reset.
- R5: A reset applied after lockout restores normal recognition, so a following 0,1,0 raises `match` again.
- R6: A 1,0 followed by a 1 does not lock. For example, 1,0,1,0 and 1,1,0,1,0 each end with `match` high.
- R7: `match` is never high in two consecutive cycles.
- R8: Parameter `ONE_HOT` (1 = one-hot, 0 = binary) selects only the state encoding. Both settings give identical `match` sequences, and the one-hot register always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; one data bit is consumed per edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data bit |
| match | output | 1 | High for one cycle after a 0,1,0 ending, while not locked out |

## Verification
The bench targets four corner cases.
- The 1,0,1 history, which is easy to misroute into the lockout path. A wrong design would miss the 0,1,0 that follows it.
- The overlapping 0,1,0,1,0 stream. A design that restarts after a match would report only one pulse.
- The 0,1,0,0 ending. A design that does not treat the match state as a source of 1,0,0 would keep matching after the lockout should have begun.
- A reset after lockout. A design that leaves the absorbing state sticky would stay silent after reset.

Both encodings run side by side on every bit, so any encoding-specific decode slip shows up as a mismatch between them.

// File: rtl/seq_lockout_pkg.sv
package seq_lockout_pkg;

  localparam int unsigned NUM_STATES = 7;

  // Symbolic states, named after the relevant suffix of the history.
  typedef enum logic [2:0] {
    S_START = 3'd0,  // nothing consumed since reset
    S_Z     = 3'd1,  // only zeros so far
    S_ZO    = 3'd2,  // history ends ..0,1
    S_ZOZ   = 3'd3,  // history ends ..0,1,0 (output state)
    S_O     = 3'd4,  // history ends ..1
    S_OZ    = 3'd5,  // history ends ..1,0
    S_DEAD  = 3'd6   // 1,0,0 has been seen
  } rec_state_e;

  function automatic rec_state_e f_next(rec_state_e s, logic b);
    rec_state_e n;
    unique case (s)
      S_START: n = b ? S_O  : S_Z;
      S_Z:     n = b ? S_ZO : S_Z;
      S_ZO:    n = b ? S_O  : S_ZOZ;
      S_ZOZ:   n = b ? S_ZO : S_DEAD;
      S_O:     n = b ? S_O  : S_OZ;
      S_OZ:    n = b ? S_ZO : S_DEAD;
      default: n = S_DEAD;
    endcase
    return n;
  endfunction

  function automatic logic [NUM_STATES-1:0] f_to_onehot(rec_state_e s);
    logic [NUM_STATES-1:0] v;
    v = '0;
    v[int'(s)] = 1'b1;
    return v;
  endfunction

  function automatic rec_state_e f_from_onehot(logic [NUM_STATES-1:0] v);
    rec_state_e s;
    s = S_DEAD;
    for (int i = NUM_STATES - 1; i >= 0; i--) begin
      if (v[i]) s = rec_state_e'(i[2:0]);
    end
    return s;
  endfunction

  function automatic int unsigned f_popcount(logic [NUM_STATES-1:0] v);
    int unsigned c;
    c = 0;
    for (int i = 0; i < NUM_STATES; i++) c += int'(v[i]);
    return c;
  endfunction

endpackage

// File: rtl/seq_lockout_next.sv
module seq_lockout_next
  import seq_lockout_pkg::*;
(
  input  rec_state_e cur,
  input  logic       bit_in,
  output rec_state_e nxt
);
  always_comb nxt = f_next(cur, bit_in);
endmodule

// File: rtl/seq_lockout_state.sv
module seq_lockout_state
  import seq_lockout_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  rec_state_e nxt,
  output rec_state_e cur,
  output logic       code_ok
);
  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM_STATES-1:0] oh_q;
      always_ff @(posedge clk) begin
        if (rst) oh_q <= f_to_onehot(S_START);
        else     oh_q <= f_to_onehot(nxt);
      end
      always_comb begin
        cur     = f_from_onehot(oh_q);
        code_ok = (f_popcount(oh_q) == 1);
      end
    end else begin : g_binary
      rec_state_e bin_q;
      always_ff @(posedge clk) begin
        if (rst) bin_q <= S_START;
        else     bin_q <= nxt;
      end
      always_comb begin
        cur     = bin_q;
        code_ok = (int'(bin_q) < NUM_STATES);
      end
    end
  endgenerate
endmodule

// File: rtl/seq_lockout_out.sv
module seq_lockout_out
  import seq_lockout_pkg::*;
(
  input  rec_state_e cur,
  output logic       hit,
  output logic       dead
);
  always_comb begin
    hit  = (cur == S_ZOZ);
    dead = (cur == S_DEAD);
  end
endmodule

// File: rtl/seq_lockout_recognizer.sv
module seq_lockout_recognizer
  import seq_lockout_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic match
);
  rec_state_e cur_s;
  rec_state_e nxt_s;
  logic       locked_w;
  logic       code_ok_w;

  seq_lockout_next u_next (
    .cur    (cur_s),
    .bit_in (din),
    .nxt    (nxt_s)
  );

  seq_lockout_state #(.ONE_HOT(ONE_HOT)) u_state (
    .clk     (clk),
    .rst     (rst),
    .nxt     (nxt_s),
    .cur     (cur_s),
    .code_ok (code_ok_w)
  );

  seq_lockout_out u_out (
    .cur  (cur_s),
    .hit  (match),
    .dead (locked_w)
  );
endmodule

// File: rtl/seq_lockout_checker.sv
module seq_lockout_checker (
  input logic clk,
  input logic rst,
  input logic din,
  input logic match,
  input logic locked,
  input logic code_ok
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!match && !locked));

  p_hit_after_010_r2: assert property (@(posedge clk) disable iff (rst)
    match |-> (!$past(din) && $past(din, 2) && !$past(din, 3)));

  p_dead_absorbs_r4: assert property (@(posedge clk) disable iff (rst)
    locked |=> (locked && !match));

  p_dead_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> (!$past(din) && !$past(din, 2) && $past(din, 3)));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    match |=> !match);

  p_code_valid_r8: assert property (@(posedge clk) disable iff (rst)
    code_ok);
endmodule

bind seq_lockout_recognizer seq_lockout_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .din     (din),
  .match   (match),
  .locked  (locked_w),
  .code_ok (code_ok_w)
);

// File: tb/seq_lockout_recognizer_bench.sv
`timescale 1ns/1ps
module seq_lockout_recognizer_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic match_oh;
  logic match_bin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state
  bit hist[$];
  bit locked_m = 1'b0;
  bit exp_m    = 1'b0;

  always #2.5 clk = ~clk;

  seq_lockout_recognizer #(.ONE_HOT(1'b1)) u_seq_lockout_recognizer (
    .clk(clk), .rst(rst), .din(din), .match(match_oh));

  seq_lockout_recognizer #(.ONE_HOT(1'b0)) u_seq_lockout_recognizer_bin (
    .clk(clk), .rst(rst), .din(din), .match(match_bin));

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: match=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_push(bit b);
    bit [2:0] last3;
    hist.push_back(b);
    exp_m = 1'b0;
    if (hist.size() >= 3) begin
      last3 = {hist[$-2], hist[$-1], hist[$]};
      if (last3 == 3'b100) locked_m = 1'b1;
      exp_m = !locked_m && (last3 == 3'b010);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    din = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    hist.delete();
    locked_m = 1'b0;
    exp_m    = 1'b0;
    check("R1", match_oh, 1'b0);
    check("R1 binary", match_bin, 1'b0);
  endtask

  task automatic step(bit b, string req);
    din = b;
    @(posedge clk);
    model_push(b);
    @(negedge clk);
    check(req, match_oh, exp_m);
    check("R8 encodings agree", match_bin, match_oh);
  endtask

  task automatic feed(bit [7:0] bits, int n, string req);
    for (int i = n - 1; i >= 0; i--) step(bits[i], req);
  endtask

  initial begin
    do_reset();
    // R2: plain 0,1,0
    feed(8'b010, 3, "R2");
    // R3: overlap continues with 1,0; R7 pulses isolated
    feed(8'b10, 2, "R3");
    step(1'b1, "R7");
    // R4: 0,1,0,0 ending then later 0,1,0 stays low
    do_reset();
    feed(8'b0100, 4, "R4");
    feed(8'b010010, 6, "R4");
    feed(8'b11111, 5, "R4");
    // R5: reset leaves lockout
    do_reset();
    feed(8'b010, 3, "R5");
    // R6: 1,0 then 1 does not lock
    do_reset();
    feed(8'b1010, 4, "R6");
    do_reset();
    feed(8'b11010, 5, "R6");
    do_reset();
    feed(8'b00010, 5, "R2");
    // Random segments, both encodings compared every bit
    for (int seg = 0; seg < 300; seg++) begin
      do_reset();
      for (int k = 0; k < 14; k++) step(1'($urandom_range(0, 1)), "R2/R4 random");
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule